// File: doc/BRIEF.md
# Coalescing Store Buffer With Load Bypass

This block sits between one in-order core and a single memory request port. Stores from the core are captured in a small line-granular buffer and acknowledged at once, so the core never waits on memory for a write. The buffered stores then drain to memory over a valid/ready request channel. A new store to a line that already has a waiting entry is folded into that entry instead of taking a fresh slot. Stores can therefore reach memory in an order that differs from program order.

A load whose line matches no buffered entry may go to memory ahead of older buffered stores. A load whose line does match waits until that entry has been written out. A fence is acknowledged only once the buffer is completely empty. Read responses from memory are passed straight back to the core.

The memory port is owned by a three-state arbiter:

- `ARB_IDLE` makes a fresh choice each cycle. A load that may bypass wins; otherwise the oldest entry is presented.
- `ARB_STORE_HOLD` is entered when a presented store is not accepted. It keeps presenting that store until memory takes it, then returns to `ARB_IDLE`.
- `ARB_LOAD_HOLD` is entered when a presented load is not accepted. It keeps presenting that load until memory takes it, then returns to `ARB_IDLE`.

Top module: `store_coalesce_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_req_valid` is low, `st_ready` is high, and `fence_ready` follows `fence_valid`.
- R2: A store that finds a free slot is accepted (`st_ready` high) in the cycle it is offered, whatever the state of `mem_req_ready`.
- R3: A load whose line matches no buffered entry is presented on the memory port in the same cycle, with `mem_req_we` low and `mem_req_line` equal to `ld_line`, unless the arbiter is holding an unaccepted store. No load is ever presented while its line matches a buffered entry.
- R4: A load whose line matches a buffered entry keeps `ld_ready` low and is not presented until every matching entry has drained.
- R5: A store to the line of a waiting entry that is not currently on the port is merged into it. Its enabled bytes overwrite the entry's bytes. The byte enables are ORed (bit k of `st_be` enables bits 8k+7..8k of `st_data`). No slot is used. Bytes a new entry does not enable are written as zero.
- R6: Entries reach memory oldest first by allocation. A merged entry keeps its original place.
- R7: With all slots in use and no merge target, `st_ready` is low.
- R8: `fence_ready` is high only while `fence_valid` is high and the buffer holds no entry.
- R9: A memory request that is presented but not accepted is presented again in the next cycle with the same line, write flag and data. A bypassing load does not displace it.
- R10: `ld_rvalid` and `ld_rdata` equal `mem_rsp_valid` and `mem_rsp_data` in the same cycle.
- R11: A store to the line of the entry currently being presented to memory takes a new slot behind the others instead of merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Core store request |
| st_ready | output | 1 | Store accepted |
| st_line | input | ADDR_W | Store line address |
| st_data | input | LINE_BYTES*8 | Store line data |
| st_be | input | LINE_BYTES | Store byte enables |
| ld_valid | input | 1 | Core load request |
| ld_ready | output | 1 | Load issued to memory |
| ld_line | input | ADDR_W | Load line address |
| ld_rvalid | output | 1 | Load response valid |
| ld_rdata | output | LINE_BYTES*8 | Load response data |
| fence_valid | input | 1 | Fence request |
| fence_ready | output | 1 | Fence acknowledged (buffer empty) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | 1 = write of a buffered line, 0 = read |
| mem_req_line | output | ADDR_W | Memory request line address |
| mem_req_data | output | LINE_BYTES*8 | Write data |
| mem_req_be | output | LINE_BYTES | Write byte enables |
| mem_rsp_valid | input | 1 | Memory read response valid |
| mem_rsp_data | input | LINE_BYTES*8 | Memory read response data |

## Verification
The checks on the memory port assume the core has at most one of store, load or fence outstanding at a time. They also assume it holds each request and its payload steady until the request is acknowledged. The load-hold state relies on exactly this to keep the presented read unchanged.

The stimulus keeps to these rules by carrying a single pending operation. That operation is retired only on its own handshake, and its fields are redrawn only afterwards. A directed prologue with memory stalled fills the buffer, merges into a non-head entry while full, and then offers a store that must wait. Random phases then vary memory readiness over a small pool of lines so that merges, conflicts and held requests recur.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE       = 2'd0,
        ARB_STORE_HOLD = 2'd1,
        ARB_LOAD_HOLD  = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_STORE = 2'd1,
        SEL_LOAD  = 2'd2
    } port_sel_t;

endpackage

// File: rtl/sb_order_queue.sv
module sb_order_queue #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] count_q;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= wrap_inc(tail_q);
            if (pop)  head_q <= wrap_inc(head_q);
            if (push && !pop)      count_q <= count_q + 1'b1;
            else if (pop && !push) count_q <= count_q - 1'b1;
        end
    end

    assign head_idx = head_q;
    assign tail_idx = tail_q;
    assign count    = count_q;
    assign full     = (count_q == CNT_W'(DEPTH));
    assign empty    = (count_q == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push && !pop |-> !full); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R6

endmodule

// File: rtl/sb_entry_array.sv
module sb_entry_array #(
    parameter int DEPTH      = 4,
    parameter int ADDR_W     = 28,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int DATA_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc_en,
    input  logic [IDX_W-1:0]      alloc_idx,
    input  logic                  merge_en,
    input  logic [IDX_W-1:0]      merge_idx,
    input  logic                  free_en,
    input  logic [IDX_W-1:0]      free_idx,
    input  logic [ADDR_W-1:0]     wr_line,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [LINE_BYTES-1:0] wr_be,
    input  logic [ADDR_W-1:0]     ld_line,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [DEPTH-1:0]      ent_vld,
    output logic [DEPTH-1:0]      st_hit,
    output logic [DEPTH-1:0]      ld_hit,
    output logic [ADDR_W-1:0]     rd_line,
    output logic [DATA_W-1:0]     rd_data,
    output logic [LINE_BYTES-1:0] rd_be
);

    logic                  vld_q  [DEPTH];
    logic [ADDR_W-1:0]     line_q [DEPTH];
    logic [DATA_W-1:0]     data_q [DEPTH];
    logic [LINE_BYTES-1:0] be_q   [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        logic hit_alloc, hit_merge, hit_free;
        assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(gi));
        assign hit_merge = merge_en && (merge_idx == IDX_W'(gi));
        assign hit_free  = free_en  && (free_idx  == IDX_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         vld_q[gi] <= 1'b0;
            else if (hit_alloc) vld_q[gi] <= 1'b1;
            else if (hit_free)  vld_q[gi] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (hit_alloc) begin
                line_q[gi] <= wr_line;
                be_q[gi]   <= wr_be;
                for (int b = 0; b < LINE_BYTES; b++)
                    data_q[gi][b*8 +: 8] <= wr_be[b] ? wr_data[b*8 +: 8] : 8'h00;
            end else if (hit_merge) begin
                be_q[gi] <= be_q[gi] | wr_be;
                for (int b = 0; b < LINE_BYTES; b++)
                    if (wr_be[b]) data_q[gi][b*8 +: 8] <= wr_data[b*8 +: 8];
            end
        end

        assign ent_vld[gi] = vld_q[gi];
        assign st_hit[gi]  = vld_q[gi] && (line_q[gi] == wr_line);
        assign ld_hit[gi]  = vld_q[gi] && (line_q[gi] == ld_line);
    end

    assign rd_line = line_q[rd_idx];
    assign rd_data = data_q[rd_idx];
    assign rd_be   = be_q[rd_idx];

    AST_ALLOC_FREE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !ent_vld[alloc_idx]); // R2

    AST_MERGE_LIVE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en |-> ent_vld[merge_idx]); // R5

endmodule

// File: rtl/sb_port_arbiter.sv
module sb_port_arbiter
    import sb_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ld_req,
    input  logic      st_avail,
    input  logic      port_ready,
    output port_sel_t sel
);

    arb_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        sel = SEL_NONE;
        unique case (state_q)
            ARB_IDLE: begin
                if (ld_req)        sel = SEL_LOAD;
                else if (st_avail) sel = SEL_STORE;
            end
            ARB_STORE_HOLD: sel = SEL_STORE;
            ARB_LOAD_HOLD:  sel = SEL_LOAD;
            default:        sel = SEL_NONE;
        endcase

        if (sel == SEL_STORE && !port_ready)     state_d = ARB_STORE_HOLD;
        else if (sel == SEL_LOAD && !port_ready) state_d = ARB_LOAD_HOLD;
        else                                     state_d = ARB_IDLE;
    end

    AST_STORE_HOLD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ARB_STORE_HOLD |-> st_avail); // R9

    AST_LOAD_HOLD_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ARB_LOAD_HOLD |-> ld_req); // R9

endmodule

// File: rtl/store_coalesce_buffer.sv
module store_coalesce_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int ADDR_W     = 28,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int DATA_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-1:0]     st_line,
    input  logic [DATA_W-1:0]     st_data,
    input  logic [LINE_BYTES-1:0] st_be,
    input  logic                  ld_valid,
    output logic                  ld_ready,
    input  logic [ADDR_W-1:0]     ld_line,
    output logic                  ld_rvalid,
    output logic [DATA_W-1:0]     ld_rdata,
    input  logic                  fence_valid,
    output logic                  fence_ready,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_we,
    output logic [ADDR_W-1:0]     mem_req_line,
    output logic [DATA_W-1:0]     mem_req_data,
    output logic [LINE_BYTES-1:0] mem_req_be,
    input  logic                  mem_rsp_valid,
    input  logic [DATA_W-1:0]     mem_rsp_data
);

    logic [IDX_W-1:0]      head_idx, tail_idx, merge_idx;
    logic [CNT_W-1:0]      count;
    logic                  full, empty;
    logic [DEPTH-1:0]      ent_vld, st_hit, ld_hit, head_mask, merge_vec;
    logic [ADDR_W-1:0]     rd_line;
    logic [DATA_W-1:0]     rd_data;
    logic [LINE_BYTES-1:0] rd_be;
    logic                  merge_hit, st_fire, alloc_en, merge_en, pop;
    logic                  ld_conflict, ld_req;
    port_sel_t             sel;

    sb_order_queue #(.DEPTH(DEPTH)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (alloc_en),
        .pop      (pop),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .count    (count),
        .full     (full),
        .empty    (empty)
    );

    sb_entry_array #(
        .DEPTH      (DEPTH),
        .ADDR_W     (ADDR_W),
        .LINE_BYTES (LINE_BYTES)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .alloc_idx (tail_idx),
        .merge_en  (merge_en),
        .merge_idx (merge_idx),
        .free_en   (pop),
        .free_idx  (head_idx),
        .wr_line   (st_line),
        .wr_data   (st_data),
        .wr_be     (st_be),
        .ld_line   (ld_line),
        .rd_idx    (head_idx),
        .ent_vld   (ent_vld),
        .st_hit    (st_hit),
        .ld_hit    (ld_hit),
        .rd_line   (rd_line),
        .rd_data   (rd_data),
        .rd_be     (rd_be)
    );

    sb_port_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_req     (ld_req),
        .st_avail   (!empty),
        .port_ready (mem_req_ready),
        .sel        (sel)
    );

    // The entry on the memory port is frozen: it never takes a merge.
    always_comb begin
        head_mask = '0;
        if (sel == SEL_STORE) head_mask[head_idx] = 1'b1;
    end

    assign merge_vec = st_hit & ~head_mask;
    assign merge_hit = |merge_vec;

    always_comb begin
        merge_idx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (merge_vec[i]) merge_idx = IDX_W'(i);
    end

    assign st_ready = merge_hit || !full;
    assign st_fire  = st_valid && st_ready;
    assign alloc_en = st_fire && !merge_hit;
    assign merge_en = st_fire && merge_hit;

    assign ld_conflict = |ld_hit;
    assign ld_req      = ld_valid && !ld_conflict;
    assign ld_ready    = (sel == SEL_LOAD) && mem_req_ready;
    assign pop         = (sel == SEL_STORE) && mem_req_ready;

    assign mem_req_valid = (sel != SEL_NONE);
    assign mem_req_we    = (sel == SEL_STORE);
    assign mem_req_line  = (sel == SEL_STORE) ? rd_line : ld_line;
    assign mem_req_data  = (sel == SEL_STORE) ? rd_data : '0;
    assign mem_req_be    = (sel == SEL_STORE) ? rd_be   : '0;

    assign fence_ready = fence_valid && empty;
    assign ld_rvalid   = mem_rsp_valid;
    assign ld_rdata    = mem_rsp_data;

    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_we)
            && $stable(mem_req_line) && $stable(mem_req_data)); // R9

    AST_LOAD_NO_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_we |-> ld_hit == '0); // R3

    AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ready |-> ent_vld == '0); // R8

    AST_COUNT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_vld) == int'(count)); // R6

    AST_MERGE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(merge_vec)); // R5

    AST_HEAD_NO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
        merge_en && mem_req_we |-> merge_idx != head_idx); // R11

endmodule

// File: tb/store_coalesce_buffer_bench.sv
module store_coalesce_buffer_bench;

    localparam int AW    = 28;
    localparam int LB    = 16;
    localparam int DW    = LB * 8;
    localparam int DEPTH = 4;
    localparam int NCYC  = 4000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, ld_valid = 1'b0, fence_valid = 1'b0;
    logic [AW-1:0] st_line = '0, ld_line = '0;
    logic [DW-1:0] st_data = '0, mem_rsp_data = '0;
    logic [LB-1:0] st_be = '0;
    logic          mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic          st_ready, ld_ready, ld_rvalid, fence_ready;
    logic          mem_req_valid, mem_req_we;
    logic [AW-1:0] mem_req_line;
    logic [DW-1:0] mem_req_data, ld_rdata;
    logic [LB-1:0] mem_req_be;

    always #5 clk = ~clk;

    store_coalesce_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .LINE_BYTES(LB)) u_store_coalesce_buffer (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_line(st_line), .st_data(st_data), .st_be(st_be),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_line(ld_line),
        .ld_rvalid(ld_rvalid), .ld_rdata(ld_rdata),
        .fence_valid(fence_valid), .fence_ready(fence_ready),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
        .mem_req_line(mem_req_line), .mem_req_data(mem_req_data), .mem_req_be(mem_req_be),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model of the buffer, index 0 is the oldest entry.
    logic [AW-1:0] m_line [8];
    logic [DW-1:0] m_data [8];
    logic [LB-1:0] m_be   [8];
    bit            m_split[8];
    int            m_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_store(input int tgt, input bit split);
        if (tgt >= 0) begin
            m_be[tgt] = m_be[tgt] | st_be;
            for (int b = 0; b < LB; b++)
                if (st_be[b]) m_data[tgt][b*8 +: 8] = st_data[b*8 +: 8];
        end else begin
            m_line[m_cnt]  = st_line;
            m_be[m_cnt]    = st_be;
            m_split[m_cnt] = split;
            for (int b = 0; b < LB; b++)
                m_data[m_cnt][b*8 +: 8] = st_be[b] ? st_data[b*8 +: 8] : 8'h00;
            m_cnt++;
        end
    endtask

    task automatic model_pop();
        for (int i = 0; i < 7; i++) begin
            m_line[i] = m_line[i+1]; m_data[i] = m_data[i+1];
            m_be[i] = m_be[i+1]; m_split[i] = m_split[i+1];
        end
        m_cnt--;
    endtask

    function automatic logic [DW-1:0] rnd_line_data();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int  op, dir_i, ready_pct, f_tgt;
        bit  op_done, f_st, f_pop, f_split, f_held, held;
        logic          h_we;
        logic [AW-1:0] h_line;
        logic [DW-1:0] h_data;
        op = 0; dir_i = 0; op_done = 1; f_st = 0; f_pop = 0; f_split = 0; f_held = 0; held = 0;
        f_tgt = -1; h_we = 0; h_line = '0; h_data = '0;
        void'($urandom(32'd20240611));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        // R1: reset state
        chk(!mem_req_valid, "R1 mem_req_valid after reset", DW'(mem_req_valid), 0);
        chk(st_ready, "R1 st_ready after reset", DW'(st_ready), 1);
        fence_valid = 1'b1;
        #1;
        chk(fence_ready, "R1 fence_ready on empty buffer", DW'(fence_ready), 1);
        fence_valid = 1'b0;

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            @(posedge clk);
            if (f_st)  model_store(f_tgt, f_split);
            if (f_pop) model_pop();
            held = f_held;
            #1;
            // drive inputs
            ready_pct = (cyc < 16) ? 0 : (cyc < 800) ? 15 : (cyc < 2400) ? 50 : 90;
            mem_req_ready = ($urandom % 100) < ready_pct;
            mem_rsp_valid = $urandom % 2;
            mem_rsp_data  = rnd_line_data();
            if (op_done) begin
                op_done = 0;
                st_valid = 0; ld_valid = 0; fence_valid = 0;
                if (dir_i < 6) begin
                    // full buffer, merge into a waiting entry, then a blocked store
                    op = 1;
                    st_line = AW'((dir_i == 4) ? 202 : (dir_i == 5) ? 204 : 200 + dir_i);
                    st_data = rnd_line_data();
                    st_be   = LB'($urandom);
                    dir_i++;
                end else begin
                    int r;
                    r = $urandom % 10;
                    op = (r < 5) ? 1 : (r < 8) ? 2 : (r < 9) ? 3 : 0;
                    st_line = AW'(100 + $urandom % 6);
                    ld_line = AW'(100 + $urandom % 6);
                    st_data = rnd_line_data();
                    st_be   = LB'($urandom);
                end
                st_valid    = (op == 1);
                ld_valid    = (op == 2);
                fence_valid = (op == 3);
                if (op == 0) op_done = 1;
            end
            #3;
            // checks
            f_st = 0; f_pop = 0; f_split = 0; f_tgt = -1;
            chk(ld_rvalid == mem_rsp_valid && ld_rdata == mem_rsp_data, "R10 response pass-through",
                ld_rdata, mem_rsp_data);
            if (held)
                chk(mem_req_valid && mem_req_we == h_we && mem_req_line == h_line && mem_req_data == h_data,
                    "R9 held request changed", DW'(mem_req_line), DW'(h_line));
            if (st_valid) begin
                bit pres, found;
                int idx;
                pres = mem_req_valid && mem_req_we;
                found = 0; idx = -1;
                for (int i = (pres ? 1 : 0); i < m_cnt; i++)
                    if (!found && m_line[i] == st_line) begin found = 1; idx = i; end
                if (!found && m_cnt == DEPTH)
                    chk(!st_ready, "R7 store accepted while full", DW'(st_ready), 0);
                else if (found)
                    chk(st_ready, "R5 merge store refused", DW'(st_ready), 1);
                else
                    chk(st_ready, "R2 store with free slot refused", DW'(st_ready), 1);
                if (st_ready) begin
                    f_st = 1; f_tgt = idx; op_done = 1;
                    f_split = pres && m_cnt > 0 && m_line[0] == st_line;
                end
            end
            if (ld_valid) begin
                bit conf;
                conf = 0;
                for (int i = 0; i < m_cnt; i++) if (m_line[i] == ld_line) conf = 1;
                if (conf)
                    chk(!ld_ready && !(mem_req_valid && !mem_req_we), "R4 conflicting load issued",
                        DW'(ld_ready), 0);
                else if (!held || !h_we)
                    chk(mem_req_valid && !mem_req_we && mem_req_line == ld_line, "R3 bypass load not presented",
                        DW'(mem_req_line), DW'(ld_line));
                if (ld_ready) op_done = 1;
            end
            if (fence_valid) begin
                chk(fence_ready == (m_cnt == 0), "R8 fence acknowledge", DW'(fence_ready), DW'(m_cnt == 0));
                if (fence_ready) op_done = 1;
            end
            if (mem_req_valid && mem_req_we) begin
                if (m_cnt == 0) chk(0, "R6 write with empty model", DW'(mem_req_line), 0);
                else begin
                    if (m_split[0])
                        chk(mem_req_line == m_line[0], "R11 split entry order", DW'(mem_req_line), DW'(m_line[0]));
                    else
                        chk(mem_req_line == m_line[0], "R6 drain order", DW'(mem_req_line), DW'(m_line[0]));
                    chk(mem_req_data == m_data[0], "R5 merged data", mem_req_data, m_data[0]);
                    chk(mem_req_be == m_be[0], "R5 merged byte enables", DW'(mem_req_be), DW'(m_be[0]));
                end
                if (mem_req_ready) f_pop = 1;
            end
            f_held = mem_req_valid && !mem_req_ready;
            h_we = mem_req_we; h_line = mem_req_line; h_data = mem_req_data;
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule